// File: doc/BRIEF.md
# ADC Result Register with Locked Byte Reads

This block turns the digital channel samples of an analog-to-digital converter into a 10-bit conversion result and presents that result as two readable bytes, a low byte and a high byte. A selector picks either one channel on its own (single-ended) or a channel pair with a gain applied to both sides (differential). Differential results that go below zero become zero, and any result above the 10-bit full scale is held at full scale.

Each done strobe from the conversion sequencer stores the freshly computed result in an internal latest-result register. Reading the low byte copies the latest result into the visible byte pair and locks the pair, so later conversions cannot tear a two-byte read. Reading the high byte releases the lock. A high-byte read that is not preceded by a low-byte read captures first, so the returned value is always current. A left-adjust control selects whether the 10 result bits sit at the bottom or the top of the 16-bit pair.

Top module: `adc_result_regs`

## Requirements
- R1: With `sel_i[3]` = 0 the result equals the 10-bit sample of channel `sel_i[2:0]`.
- R2: With `sel_i[3]` = 1 the result is P×G − N×G, where P is channel `sel_i[2:0]`, N is channel `sel_i[2:0]` XOR 1, and G is set by `gain_i`: 0 gives 1, 1 gives 10, 2 gives 200, 3 gives 1.
- R3: A differential difference below zero yields a result of 0.
- R4: Any result above 0x3FF yields 0x3FF.
- R5: The 16-bit pair {`hi_o`,`lo_o`} holds the result in bits 9:0 with zeros above when `adj_i` = 0 at the capture cycle, and holds it in bits 15:6 with zeros below when `adj_i` = 1.
- R6: A `done_i` pulse stores the result computed from the inputs of that cycle in the latest-result register; on its own it leaves the visible pair unchanged.
- R7: `rd_lo_i` while unlocked copies the latest result (or, when `done_i` is high in the same cycle, that cycle's new result) into the pair, visible one cycle later, and sets the lock.
- R8: While locked, `done_i`, further `rd_lo_i` pulses and changes of `adj_i` or the samples leave the pair unchanged.
- R9: `rd_hi_i` while locked clears the lock and leaves the pair unchanged; `rd_hi_i` while unlocked performs the same capture as R7 and leaves the lock clear.
- R10: Synchronous reset clears the pair, the lock and the latest-result register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| samp_i | input | NCH*SW (80) | Channel samples, channel k in bits k*SW+SW-1 : k*SW |
| sel_i | input | $clog2(NCH)+1 (4) | Channel select; top bit chooses differential mode |
| gain_i | input | 2 | Differential gain code |
| adj_i | input | 1 | Left-adjust control, sampled at capture |
| done_i | input | 1 | Conversion-done strobe |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_hi_i | input | 1 | High-byte read strobe |
| lo_o | output | 8 | Low byte of the visible pair |
| hi_o | output | 8 | High byte of the visible pair |

## Verification
The latest-result register loads on the rising edge that sees `done_i`, and the visible pair loads on the rising edge that sees a capturing read strobe, so every byte value is due exactly one cycle after its strobe. The bench drives each strobe at a falling edge, releases it at the next falling edge, and compares both bytes at that second falling edge, half a cycle after the capturing edge. A reference model in the bench tracks the pair, the lock and the latest result from the requirements, and sweeps every channel, both modes, all gain codes and both alignments, plus locked-read sequences checked against literal values.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  localparam int BYTE_W = 8;
  localparam int PAIR_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    GAIN_UNITY = 2'd0,
    GAIN_MID   = 2'd1,
    GAIN_HIGH  = 2'd2,
    GAIN_ALT   = 2'd3
  } gain_code_t;
endpackage

// File: rtl/adcr_calc.sv
module adcr_calc #(
  parameter int NCH = 8,
  parameter int SW  = 10,
  parameter int RW  = 10,
  parameter int G1  = 10,
  parameter int G2  = 200
) (
  input  logic [NCH*SW-1:0]      samp_i,
  input  logic [$clog2(NCH):0]   sel_i,
  input  logic [1:0]             gain_i,
  output logic [RW-1:0]          res_o
);
  import adcr_pkg::*;

  localparam int CHW = $clog2(NCH);
  localparam int PW  = SW + $clog2(G2 + 1);
  localparam logic [PW-1:0] MAXV = PW'((1 << RW) - 1);

  logic [SW-1:0] ch [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign ch[g] = samp_i[g*SW +: SW];
  end

  logic [CHW-1:0] pos_idx, neg_idx;
  logic [PW-1:0]  gmul, pos_p, neg_p, single_v;
  logic [PW:0]    diff_v;
  gain_code_t     gcode;

  always_comb begin
    gcode   = gain_code_t'(gain_i);
    pos_idx = sel_i[CHW-1:0];
    neg_idx = sel_i[CHW-1:0] ^ CHW'(1);
    unique case (gcode)
      GAIN_MID:  gmul = PW'(G1);
      GAIN_HIGH: gmul = PW'(G2);
      default:   gmul = PW'(1);
    endcase
    pos_p    = PW'(ch[pos_idx]) * gmul;
    neg_p    = PW'(ch[neg_idx]) * gmul;
    diff_v   = {1'b0, pos_p} - {1'b0, neg_p};
    single_v = PW'(ch[pos_idx]);
    if (sel_i[CHW]) begin
      if (diff_v[PW])
        res_o = '0;
      else if (diff_v[PW-1:0] > MAXV)
        res_o = MAXV[RW-1:0];
      else
        res_o = diff_v[RW-1:0];
    end else begin
      if (single_v > MAXV)
        res_o = MAXV[RW-1:0];
      else
        res_o = single_v[RW-1:0];
    end
  end
endmodule

// File: rtl/adcr_align.sv
module adcr_align #(
  parameter int RW = 10
) (
  input  logic [RW-1:0]                res_i,
  input  logic                         adj_i,
  output logic [adcr_pkg::PAIR_W-1:0]  pair_o
);
  import adcr_pkg::*;

  localparam int PAD = PAIR_W - RW;

  always_comb begin
    if (adj_i)
      pair_o = {res_i, {PAD{1'b0}}};
    else
      pair_o = {{PAD{1'b0}}, res_i};
  end
endmodule

// File: rtl/adcr_pair.sv
module adcr_pair #(
  parameter int RW = 10
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic [RW-1:0]                res_i,
  input  logic                         adj_i,
  input  logic                         done_i,
  input  logic                         rd_lo_i,
  input  logic                         rd_hi_i,
  output logic [adcr_pkg::PAIR_W-1:0]  pair_o,
  output logic                         lock_o,
  output logic [RW-1:0]                latest_o
);
  import adcr_pkg::*;

  logic [RW-1:0]     latest_q;
  logic [PAIR_W-1:0] pair_q;
  logic [PAIR_W-1:0] pair_d;
  logic [RW-1:0]     cap_src;
  logic              lock_q;
  logic              cap;

  assign cap_src = done_i ? res_i : latest_q;
  assign cap     = (rd_lo_i | rd_hi_i) & ~lock_q;

  adcr_align #(.RW(RW)) u_align (
    .res_i  (cap_src),
    .adj_i  (adj_i),
    .pair_o (pair_d)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      latest_q <= '0;
      pair_q   <= '0;
      lock_q   <= 1'b0;
    end else begin
      if (done_i) latest_q <= res_i;
      if (cap)    pair_q   <= pair_d;
      if (rd_hi_i)
        lock_q <= 1'b0;
      else if (rd_lo_i)
        lock_q <= 1'b1;
    end
  end

  assign pair_o   = pair_q;
  assign lock_o   = lock_q;
  assign latest_o = latest_q;
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int NCH = 8,
  parameter int SW  = 10,
  parameter int RW  = 10,
  parameter int G1  = 10,
  parameter int G2  = 200
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic [NCH*SW-1:0]      samp_i,
  input  logic [$clog2(NCH):0]   sel_i,
  input  logic [1:0]             gain_i,
  input  logic                   adj_i,
  input  logic                   done_i,
  input  logic                   rd_lo_i,
  input  logic                   rd_hi_i,
  output logic [7:0]             lo_o,
  output logic [7:0]             hi_o
);
  import adcr_pkg::*;

  logic [RW-1:0]     res_w;
  logic [RW-1:0]     latest_w;
  logic [PAIR_W-1:0] pair_w;
  logic              lock_w;

  adcr_calc #(.NCH(NCH), .SW(SW), .RW(RW), .G1(G1), .G2(G2)) u_calc (
    .samp_i (samp_i),
    .sel_i  (sel_i),
    .gain_i (gain_i),
    .res_o  (res_w)
  );

  adcr_pair #(.RW(RW)) u_pair (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .res_i    (res_w),
    .adj_i    (adj_i),
    .done_i   (done_i),
    .rd_lo_i  (rd_lo_i),
    .rd_hi_i  (rd_hi_i),
    .pair_o   (pair_w),
    .lock_o   (lock_w),
    .latest_o (latest_w)
  );

  assign lo_o = pair_w[BYTE_W-1:0];
  assign hi_o = pair_w[PAIR_W-1:BYTE_W];
endmodule

// File: rtl/adcr_chk.sv
module adcr_chk #(
  parameter int RW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          rd_lo,
  input logic          rd_hi,
  input logic          adj,
  input logic          lock,
  input logic [RW-1:0] latest,
  input logic [7:0]    lo,
  input logic [7:0]    hi
);
  localparam int PAD = 16 - RW;

  // R7
  lock_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !rd_hi) |=> lock);

  // R9
  lock_release_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> !lock);

  // R8
  frozen_pair_chk: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable({hi, lo}));

  // R6
  no_capture_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_lo || rd_hi) |=> $stable({hi, lo}));

  // R5
  right_align_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_lo || rd_hi) && !lock && !adj) |=> ({hi, lo} >> RW) == 16'd0);

  // R5
  left_align_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_lo || rd_hi) && !lock && adj) |=> ({hi, lo} << (16 - PAD)) == 16'd0);

  // R6
  latest_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(latest));
endmodule

bind adc_result_regs adcr_chk #(.RW(RW)) chk_i (
  .clk    (clk_i),
  .rst    (rst_i),
  .done   (done_i),
  .rd_lo  (rd_lo_i),
  .rd_hi  (rd_hi_i),
  .adj    (adj_i),
  .lock   (lock_w),
  .latest (latest_w),
  .lo     (lo_o),
  .hi     (hi_o)
);

// File: tb/adc_result_regs_tb.sv
module adc_result_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [79:0] samp;
  logic [3:0]  sel;
  logic [1:0]  gain;
  logic        adj, done, rd_lo, rd_hi;
  logic [7:0]  lo, hi;
  logic [9:0]  smp [8];

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [15:0] m_pair;
  logic [9:0]  m_latest;
  logic        m_lock;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < 8; i++) samp[i*10 +: 10] = smp[i];

  adc_result_regs dut_i (
    .clk_i(clk), .rst_i(rst), .samp_i(samp), .sel_i(sel), .gain_i(gain),
    .adj_i(adj), .done_i(done), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
    .lo_o(lo), .hi_o(hi)
  );

  function automatic int exp_res();
    int g, p, n, r;
    g = (gain == 2'd1) ? 10 : (gain == 2'd2) ? 200 : 1;
    p = int'(smp[sel[2:0]]);
    n = int'(smp[sel[2:0] ^ 3'd1]);
    r = sel[3] ? (p * g - n * g) : p;
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  function automatic logic [15:0] fmt(input logic [9:0] r, input logic a);
    return a ? {r, 6'd0} : {6'd0, r};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // One strobe cycle: drive at a falling edge, compare at the next one.
  task automatic cyc(input logic d, input logic l, input logic h, input string tag);
    logic [9:0] r;
    @(negedge clk);
    done = d; rd_lo = l; rd_hi = h;
    r = 10'(exp_res());
    if ((l | h) && !m_lock) m_pair = fmt(d ? r : m_latest, adj);
    if (d) m_latest = r;
    if (h) m_lock = 1'b0;
    else if (l) m_lock = 1'b1;
    @(negedge clk);
    done = 0; rd_lo = 0; rd_hi = 0;
    check(tag, {hi, lo}, m_pair);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    rst = 1; done = 0; rd_lo = 0; rd_hi = 0; adj = 0; sel = 0; gain = 0;
    for (int i = 0; i < 8; i++) smp[i] = 10'h155;
    m_pair = 0; m_latest = 0; m_lock = 0;
    repeat (3) @(negedge clk);
    check("R10 reset pair", {hi, lo}, 16'h0000);
    rst = 0;
    // R10: latest register is zero after reset, high read captures it
    cyc(0, 0, 1, "R10 latest cleared");
    check("R10 literal", {hi, lo}, 16'h0000);

    // R1 R5 R6 R7 R9: single-ended sweep
    for (int ch = 0; ch < 8; ch++)
      for (int k = 0; k < 6; k++)
        for (int a = 0; a < 2; a++) begin
          for (int i = 0; i < 8; i++) smp[i] = 10'((i * 97 + k * 211 + ch * 13) % 1024);
          if (k == 4) smp[ch] = 10'h3FF;
          if (k == 5) smp[ch] = 10'h000;
          sel = {1'b0, 3'(ch)}; adj = a[0];
          cyc(1, 0, 0, "R6 done alone");
          cyc(0, 1, 0, "R1 R7 low read");
          cyc(0, 0, 1, "R9 high read locked");
        end

    // R2 R3 R4: differential sweep, done together with low read
    for (int ch = 0; ch < 8; ch++)
      for (int gc = 0; gc < 4; gc++)
        for (int v = 0; v < 5; v++) begin
          int pv, nv;
          case (v)
            0: begin pv = 500; nv = 100; end
            1: begin pv = 100; nv = 500; end
            2: begin pv = 1023; nv = 0; end
            3: begin pv = 3; nv = 2; end
            default: begin pv = 60; nv = 55; end
          endcase
          smp[ch] = 10'(pv); smp[ch ^ 1] = 10'(nv);
          sel = {1'b1, 3'(ch)}; gain = 2'(gc); adj = v[0];
          cyc(1, 1, 0, "R2 R3 R4 R7 same-cycle capture");
          cyc(0, 0, 1, "R9 release");
        end

    // R5 literal alignment
    sel = 4'd5; smp[5] = 10'h2AB; adj = 1;
    cyc(1, 0, 0, "R6 done");
    cyc(0, 1, 0, "R5 left");
    check("R5 left literal", {hi, lo}, 16'hAAC0);
    cyc(0, 0, 1, "R9 release");
    adj = 0;
    cyc(0, 0, 1, "R5 right");
    check("R5 right literal", {hi, lo}, 16'h02AB);

    // R3 R4 literals
    sel = 4'b1010; gain = 2'd2; smp[2] = 10'd1023; smp[3] = 10'd0;
    cyc(1, 1, 0, "R4 clip");
    check("R4 clip literal", {hi, lo}, 16'h03FF);
    cyc(0, 0, 1, "R9 release");
    smp[2] = 10'd4; smp[3] = 10'd9;
    cyc(1, 1, 0, "R3 negative");
    check("R3 negative literal", {hi, lo}, 16'h0000);
    cyc(0, 0, 1, "R9 release");

    // R8: locked pair ignores done, low reads, adj and sample changes
    sel = 4'd1; gain = 0; smp[1] = 10'h123; adj = 0;
    cyc(1, 1, 0, "R7 lock");
    check("R7 lock literal", {hi, lo}, 16'h0123);
    smp[1] = 10'h0F0;
    cyc(1, 0, 0, "R8 done locked");
    adj = 1;
    cyc(0, 1, 0, "R8 low read locked");
    check("R8 frozen literal", {hi, lo}, 16'h0123);
    cyc(0, 0, 1, "R9 release keeps pair");
    check("R9 release literal", {hi, lo}, 16'h0123);
    // R9: high read without low read captures the newer result
    adj = 0;
    cyc(0, 0, 1, "R9 high first");
    check("R9 high first literal", {hi, lo}, 16'h00F0);
    smp[1] = 10'h301;
    cyc(1, 0, 1, "R9 high first with done");
    check("R9 high first done literal", {hi, lo}, 16'h0301);
    // lock stays clear after unlocked high read: a done then low read is current
    smp[1] = 10'h011;
    cyc(1, 0, 0, "R6 done");
    cyc(0, 1, 0, "R9 lock stayed clear");
    check("R9 lock clear literal", {hi, lo}, 16'h0011);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule